// File: doc/BRIEF.md
# Thermal Throttling Duty-Cycle Gate

This block keeps a processor within its thermal limits by suppressing clock cycles. Operating voltage and frequency are left alone. It takes a junction-temperature code, seven programmable rising thresholds and a hysteresis margin. From these it picks a throttle level from T0 (normal running) to T7 (the hottest).

Each level maps to a fixed number of suppressed cycles in every 16-cycle window. An accumulator spreads those cycles evenly across the window instead of gating them in one burst. The output is a per-cycle clock enable, intended to feed a clock-gating cell outside the block.

A new level is taken only at a window boundary. A lower level needs the temperature to fall below a threshold by the hysteresis margin, which stops the level from chattering around a threshold.

Top module: `thermal_throttle_gate`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, level_o is 0 and clk_en_o is 1. The window phase restarts at 0 in that first cycle.
- R2: At level 0, clk_en_o stays 1 in every cycle.
- R3: At level L the number of gated cycles in each 16-cycle window is 2*L for L from 1 to 6, and 15 for L = 7. So T1 gates one eighth and T2 one quarter.
- R4: Within a window, with g gated cycles and phase p (0 to 15), clk_en_o is 0 exactly when floor((p+1)*g/16) > floor(p*g/16).
- R5: The rising target is the count of thresholds k (1 to 7) with temp_i >= threshold k. Threshold k sits in thr_i[(k-1)*8 +: 8]. When the target exceeds the current level, the level moves to the target.
- R6: The falling target is the count of thresholds k with temp_i + hyst_i >= threshold k. When it is below the current level, the level moves to it. Otherwise the level is held, so a temperature inside the hysteresis band causes no change.
- R7: The level is updated only at the clock edge that ends phase 15, using the inputs at that edge. The new level governs clk_en_o from phase 0 of the next window.
- R8: When at most half of the cycles of a window are gated (level 0 to 4), no two consecutive cycles are gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| temp_i | input | 8 | Junction-temperature code |
| thr_i | input | 56 | Seven rising thresholds, level k in bits (k-1)*8 +: 8 |
| hyst_i | input | 8 | Hysteresis margin for falling transitions |
| clk_en_o | output | 1 | Per-cycle clock enable, 0 = cycle suppressed |
| level_o | output | 3 | Current throttle level |

## Verification
Both clk_en_o and level_o are driven from registers only. Each is therefore known for a cycle as soon as the preceding edge has passed.

A temperature change affects level_o no earlier than the edge that closes phase 15. It affects clk_en_o from phase 0 of the following window. The bench keeps a phase count from reset release and changes temp_i only at falling edges. It compares both outputs at every falling edge against a model level. That model level advances only when the modelled phase wraps. The bench also tallies the gated cycles of each window and compares the tally once the window's sixteenth cycle has been sampled.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int WIN_W   = 4;
  localparam int WIN     = 1 << WIN_W;

  // gated cycles per window for a level
  function automatic logic [WIN_W:0] gate_cnt(input logic [LVL_W-1:0] lvl);
    if (int'(lvl) == NUM_LVL - 1) return (WIN_W+1)'(WIN - 1);
    return (WIN_W+1)'(2 * int'(lvl));
  endfunction
endpackage

// File: rtl/tt_level_sel.sv
module tt_level_sel
  import tt_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic [TEMP_W-1:0]             temp_i,
  input  logic [(NUM_LVL-1)*TEMP_W-1:0] thr_i,
  input  logic [TEMP_W-1:0]             hyst_i,
  input  logic [LVL_W-1:0]              cur_i,
  output logic [LVL_W-1:0]              nxt_o
);
  logic [LVL_W-1:0] up_lvl, dn_lvl;

  always_comb begin
    up_lvl = '0;
    dn_lvl = '0;
    for (int k = 1; k < NUM_LVL; k++) begin
      if ({1'b0, temp_i} >= {1'b0, thr_i[(k-1)*TEMP_W +: TEMP_W]})
        up_lvl = up_lvl + 1'b1;
      if (({1'b0, temp_i} + {1'b0, hyst_i}) >= {1'b0, thr_i[(k-1)*TEMP_W +: TEMP_W]})
        dn_lvl = dn_lvl + 1'b1;
    end
  end

  always_comb begin
    if (up_lvl > cur_i)      nxt_o = up_lvl;
    else if (dn_lvl < cur_i) nxt_o = dn_lvl;
    else                     nxt_o = cur_i;
  end

  // R6: a drop never lands below the rising target
  always_comb a_r6_drop_floor: assert (nxt_o >= up_lvl || nxt_o == cur_i);
endmodule

// File: rtl/tt_window.sv
module tt_window
  import tt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic first_o,
  output logic last_o
);
  logic [WIN_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + 1'b1;
  end

  assign first_o = (phase_q == '0);
  assign last_o  = (phase_q == WIN_W'(WIN - 1));

  a_r7_boundary_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> first_o);
endmodule

// File: rtl/tt_duty.sv
module tt_duty
  import tt_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           first_i,
  input  logic [WIN_W:0] gcnt_i,
  output logic           en_o
);
  logic [WIN_W-1:0] acc_q;
  logic [WIN_W:0]   sum;

  assign sum  = {1'b0, acc_q} + gcnt_i;
  assign en_o = ~sum[WIN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[WIN_W-1:0];
  end

  // R3: exact count per window needs an empty accumulator at each start
  a_r3_acc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_i |-> acc_q == '0);

  a_r8_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gcnt_i <= (WIN_W+1)'(WIN / 2) && !en_o) |=> en_o);
endmodule

// File: rtl/thermal_throttle_gate.sv
module thermal_throttle_gate
  import tt_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [TEMP_W-1:0]             temp_i,
  input  logic [(NUM_LVL-1)*TEMP_W-1:0] thr_i,
  input  logic [TEMP_W-1:0]             hyst_i,
  output logic                          clk_en_o,
  output logic [LVL_W-1:0]              level_o
);
  logic             first, last;
  logic [LVL_W-1:0] level_q, level_nxt;

  tt_window i_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_o (first),
    .last_o  (last)
  );

  tt_level_sel #(.TEMP_W(TEMP_W)) i_level_sel (
    .temp_i (temp_i),
    .thr_i  (thr_i),
    .hyst_i (hyst_i),
    .cur_i  (level_q),
    .nxt_o  (level_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   level_q <= '0;
    else if (last) level_q <= level_nxt;
  end

  tt_duty i_duty (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_i (first),
    .gcnt_i  (gate_cnt(level_q)),
    .en_o    (clk_en_o)
  );

  assign level_o = level_q;

  a_r2_t0_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q == '0 |-> clk_en_o);

  a_r7_level_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(level_q));

  a_r7_window_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> first);
endmodule

// File: tb/test_thermal_throttle_gate.sv
module test_thermal_throttle_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  temp_i = '0;
  logic [55:0] thr_i;
  logic [7:0]  hyst_i = 8'd6;
  logic        clk_en_o;
  logic [2:0]  level_o;

  int n_chk = 0, n_bad = 0;
  int exp_lvl = 0, ph = 0, gated = 0;
  int thr [1:7] = '{40, 60, 80, 100, 120, 140, 160};

  always #4 clk_i = ~clk_i;

  thermal_throttle_gate i_thermal_throttle_gate (
    .clk_i, .rst_ni, .temp_i, .thr_i, .hyst_i, .clk_en_o, .level_o
  );

  function automatic int gcnt(int l);
    return (l == 7) ? 15 : 2 * l;
  endfunction

  function automatic bit en_exp(int l, int p);
    int g = gcnt(l);
    return !(((p + 1) * g) / 16 > (p * g) / 16);
  endfunction

  function automatic int next_lvl(int cur, int t, int h);
    int up = 0, dn = 0;
    for (int k = 1; k <= 7; k++) begin
      if (t >= thr[k]) up++;
      if (t + h >= thr[k]) dn++;
    end
    if (up > cur) return up;
    if (dn < cur) return dn;
    return cur;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (phase %0d)", req, act, exp, ph);
    end
  endtask

  // one cycle: called just after a negedge with temp_i already set for the coming edge
  task automatic step(int t);
    temp_i = 8'(t);
    check("R5/R6/R7 level", int'(level_o), exp_lvl);
    check(exp_lvl == 0 ? "R2 enable" : "R4 enable", int'(clk_en_o), int'(en_exp(exp_lvl, ph)));
    if (!clk_en_o) gated++;
    if (ph == 15) begin
      check("R3 window count", gated, gcnt(exp_lvl));
      gated = 0;
      exp_lvl = next_lvl(exp_lvl, t, int'(hyst_i));
    end
    ph = (ph + 1) % 16;
    @(negedge clk_i);
  endtask

  task automatic run_window(int t);
    for (int i = 0; i < 16; i++) step(t);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 1; k <= 7; k++) thr_i[(k-1)*8 +: 8] = 8'(thr[k]);
    temp_i = 8'd200;
    repeat (3) @(negedge clk_i);
    check("R1 reset level", int'(level_o), 0);
    check("R1 reset enable", int'(clk_en_o), 1);
    rst_ni = 1'b1;
    check("R1 first cycle level", int'(level_o), 0);
    // directed: each level in turn, two windows each
    for (int l = 0; l <= 7; l++) begin
      run_window(l == 0 ? 20 : thr[l] + 2);
      run_window(l == 0 ? 20 : thr[l] + 2);
    end
    // R6: inside the hysteresis band the level holds at 7
    run_window(thr[7] - 3);
    run_window(thr[7] - 3);
    check("R6 hold in band", int'(level_o), 7);
    // R6: below the band it drops
    run_window(thr[7] - 10);
    run_window(thr[7] - 10);
    check("R6 drop below band", int'(level_o), 6);
    // R7: mid-window spike then cooled before boundary gives no rise
    run_window(10);
    run_window(10);
    for (int i = 0; i < 8; i++) step(250);
    for (int i = 0; i < 8; i++) step(10);
    step(10);
    check("R7 spike ignored", int'(level_o), 0);
    for (int i = 0; i < 15; i++) step(10);
    // random: temperatures drift
    begin
      int seed_v = $urandom(1234);
      int t = 90;
      for (int w = 0; w < 300; w++) begin
        t = t + int'($urandom_range(0, 40)) - 20;
        if (t < 0) t = 0;
        if (t > 255) t = 255;
        for (int i = 0; i < 16; i++) step((i == 15) ? t : int'($urandom_range(0, 255)));
      end
      seed_v = seed_v + 0;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule